// File: doc/BRIEF.md
# Split Serial Register Controller

This block is a serial access register that sits next to a row-organised memory array. It holds one row's worth of entries, 512 entries of 4 bits at the default size. A transfer read copies a row from the array's wide parallel port into the register. A transfer write hands the register contents back to the array so that the array can store them in any row in one cycle. Between transfers the register is streamed through a nibble-wide serial port, one entry per serial step. Each step either reads the entry at the pointer or writes an external nibble into it, then moves the pointer on.

The block has two modes. In single mode the register is one ring: a transfer read loads every entry, and the pointer wraps from the last entry to entry 0. In split mode the register is two halves. The half the pointer is in is the active half and keeps streaming. The other half can be reloaded or written back at the same time. When the pointer passes the last entry of the active half, it moves straight into the opposite half at a start offset recorded by the last accepted reload. A flag output shows which half the pointer is in. A transfer in split mode that names the active half is refused and reported with a one-cycle error pulse.

The serial clock enters as a synchronous step strobe sampled on the system clock. Row addressing belongs to the array; the block receives only the column tap, whose top bit selects the half.

Top module: `ssr_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, the outputs read as follows: `ser_dout` = 0, `half_flag` = 0, `row_we` = 2'b00, `xfer_err` = 0. The pointer and the stored split offset are both 0.
- R2: In single mode (`split_mode`=0), `xfer_rd` loads entry n from `row_in[n*DW +: DW]` for every n and sets the pointer to `tap`. The result is visible the cycle after the strobe.
- R3: `ser_dout` always shows the entry at the pointer. With `ser_in_mode`=0, each `ser_step` moves the pointer one entry forward. With no step and no load, the pointer holds.
- R4: In single mode the pointer wraps from DEPTH-1 to 0. `half_flag` always equals the pointer's top bit: 0 for the lower half (entries below DEPTH/2), 1 for the upper half.
- R5: In split mode, a step taken at the last entry of the active half moves the pointer to the opposite half. The new offset within that half is the low bits of the tap from the last accepted split transfer read, or 0 if there has been none since reset.
- R6: In split mode, `xfer_rd` with `tap[AW-1]` naming the inactive half loads only that half from `row_in`. It records `tap[AW-2:0]` as the offset for the next handover. The active half's contents and the pointer are left unchanged.
- R7: In split mode, an `xfer_rd` or `xfer_wr` whose `tap[AW-1]` equals `half_flag` is ignored: no entry changes and `row_we` stays 2'b00. `xfer_err` is 1 on the following cycle only.
- R8: With `ser_in_mode`=1, each step writes `ser_din` into the entry at the pointer and then advances the pointer as in R3 to R5.
- R9: `xfer_wr` raises `row_we` on the next cycle. It is 2'b11 in single mode. In split mode it is the one-hot code of the inactive half named by `tap[AW-1]` (bit 0 for the lower half, bit 1 for the upper half). `row_wdata` carries the register contents, entry n in bits `[n*DW +: DW]`.
- R10: In single mode, a transfer read in the same cycle as a step takes priority. The pointer becomes `tap`, and no serial write takes place.
- R11: In split mode, when a handover step coincides with an accepted reload of the half being entered, the pointer takes the offset from that reload's tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | 1 = split (two halves), 0 = single ring |
| ser_in_mode | input | 1 | 1 = serial input, 0 = serial output |
| xfer_rd | input | 1 | Transfer read strobe (array to register) |
| xfer_wr | input | 1 | Transfer write strobe (register to array) |
| tap | input | AW | Column tap; top bit selects the half in split mode |
| row_in | input | DEPTH*DW | Row data from the array |
| row_wdata | output | DEPTH*DW | Register contents toward the array |
| row_we | output | 2 | Per-half write enable toward the array |
| ser_step | input | 1 | Serial clock step, one entry per pulse |
| ser_din | input | DW | Serial input nibble |
| ser_dout | output | DW | Entry at the pointer |
| half_flag | output | 1 | Active half (pointer top bit) |
| xfer_err | output | 1 | One-cycle pulse for a refused split transfer |

## Verification
The bench runs a 16-entry configuration and aims at the handover entry. A wrong handover would keep streaming inside the same half, or land at offset 0 instead of the loaded offset. The bench sweeps every tap for full loads and every offset for split reloads, including a reload that lands in the very cycle of the handover; a design that used the stale offset would jump to the old position. Transfers naming the active half are driven on purpose: a design that accepted them would overwrite the entries being streamed or raise a write enable. The bench also drives a full load together with a serial write, where a design with the wrong priority would corrupt the new row.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int SSR_DEPTH_DEF = 512;
  localparam int SSR_DW_DEF    = 4;

  // one-hot code of a half: bit 0 lower, bit 1 upper
  function automatic logic [1:0] half_code(input logic upper);
    return upper ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/ssr_ptr.sv
module ssr_ptr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          split,
  input  logic          ld_full,
  input  logic          ld_half,
  input  logic          step,
  input  logic [AW-1:0] tap,
  output logic [AW-1:0] ptr
);
  localparam int OW = AW - 1;
  localparam logic [OW-1:0] OFS_LAST = '1;

  logic [OW-1:0] ofs_q, ofs_d;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ofs_d = ofs_q;
    if (ld_half) ofs_d = tap[OW-1:0];
    ptr_d = ptr;
    if (ld_full) begin
      ptr_d = tap;
    end else if (step) begin
      if (split && (ptr[OW-1:0] == OFS_LAST)) ptr_d = {~ptr[AW-1], ofs_d};
      else                                     ptr_d = ptr + 1'b1;
    end
  end

  assign ptr_en = ld_full | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      ofs_q <= '0;
    end else begin
      if (ptr_en)  ptr   <= ptr_d;
      if (ld_half) ofs_q <= ofs_d;
    end
  end

  p_single_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!split && step && !ld_full && ptr == '1) |=> (ptr == '0));

  p_handover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (split && step && !ld_full && ptr[OW-1:0] == OFS_LAST) |=> (ptr[AW-1] != $past(ptr[AW-1])));

  p_half_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (split && step && !ld_full && ptr[OW-1:0] != OFS_LAST) |=> $stable(ptr[AW-1]));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_full) |=> $stable(ptr));
endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
  parameter int DEPTH = 512,
  parameter int DW    = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          ld_mask,
  input  logic [DEPTH*DW-1:0] row_in,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       din,
  output logic [DEPTH*DW-1:0] bank,
  output logic [DW-1:0]       rd_data
);
  localparam int HALF = DEPTH / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((i >= HALF) ? ld_mask[1] : ld_mask[0])
          bank[i*DW +: DW] <= row_in[i*DW +: DW];
        else if (wr_en && (addr == AW'(i)))
          bank[i*DW +: DW] <= din;
      end
    end
  end

  assign rd_data = bank[addr*DW +: DW];

  p_full_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mask == 2'b11) |=> (bank == $past(row_in)));

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_mask == 2'b00 && !wr_en) |=> $stable(bank));
endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
#(
  parameter int DEPTH = SSR_DEPTH_DEF,
  parameter int DW    = SSR_DW_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       split_mode,
  input  logic                       ser_in_mode,
  input  logic                       xfer_rd,
  input  logic                       xfer_wr,
  input  logic [$clog2(DEPTH)-1:0]   tap,
  input  logic [DEPTH*DW-1:0]        row_in,
  output logic [DEPTH*DW-1:0]        row_wdata,
  output logic [1:0]                 row_we,
  input  logic                       ser_step,
  input  logic [DW-1:0]              ser_din,
  output logic [DW-1:0]              ser_dout,
  output logic                       half_flag,
  output logic                       xfer_err
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] ptr;
  logic          active_hi, req_hi;
  logic          rd_clash, wr_clash;
  logic          ld_full, ld_half, ser_wr;
  logic [1:0]    ld_mask, we_d;
  logic          err_d;

  assign active_hi = ptr[AW-1];
  assign req_hi    = tap[AW-1];
  assign half_flag = active_hi;

  // transfer acceptance
  always_comb begin
    rd_clash = split_mode & xfer_rd & (req_hi == active_hi);
    wr_clash = split_mode & xfer_wr & (req_hi == active_hi);
    ld_full  = ~split_mode & xfer_rd;
    ld_half  = split_mode & xfer_rd & ~rd_clash;
    if (ld_full)      ld_mask = 2'b11;
    else if (ld_half) ld_mask = half_code(req_hi);
    else              ld_mask = 2'b00;
    if (!xfer_wr)        we_d = 2'b00;
    else if (!split_mode) we_d = 2'b11;
    else if (wr_clash)   we_d = 2'b00;
    else                 we_d = half_code(req_hi);
    err_d  = rd_clash | wr_clash;
    ser_wr = ser_step & ser_in_mode & ~ld_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_we   <= 2'b00;
      xfer_err <= 1'b0;
    end else begin
      row_we   <= we_d;
      xfer_err <= err_d;
    end
  end

  ssr_ptr #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .split   (split_mode),
    .ld_full (ld_full),
    .ld_half (ld_half),
    .step    (ser_step),
    .tap     (tap),
    .ptr     (ptr)
  );

  ssr_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_mask (ld_mask),
    .row_in  (row_in),
    .wr_en   (ser_wr),
    .addr    (ptr),
    .din     (ser_din),
    .bank    (row_wdata),
    .rd_data (ser_dout)
  );

  p_clash_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && xfer_wr && tap[AW-1] == half_flag) |=> (row_we == 2'b00 && xfer_err));

  p_clash_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && xfer_rd && tap[AW-1] == half_flag) |=> xfer_err);

  p_split_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && xfer_wr && tap[AW-1] != half_flag) |=> ($countones(row_we) == 1));

  p_single_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_mode && xfer_wr) |=> (row_we == 2'b11));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_wr) |=> (row_we == 2'b00));
endmodule

// File: tb/sim_ssr_ctrl.sv
`timescale 1ns/1ps
module sim_ssr_ctrl;
  localparam int DEPTH = 16;
  localparam int DW    = 4;
  localparam int AW    = 4;
  localparam int RW    = DEPTH * DW;

  logic          clk, rst_n;
  logic          split_mode, ser_in_mode, xfer_rd, xfer_wr, ser_step;
  logic [AW-1:0] tap;
  logic [RW-1:0] row_in, row_wdata;
  logic [1:0]    row_we;
  logic [DW-1:0] ser_din, ser_dout;
  logic          half_flag, xfer_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_ptr;
  logic [AW-2:0] m_ofs;

  ssr_ctrl #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .ser_in_mode(ser_in_mode),
    .xfer_rd(xfer_rd), .xfer_wr(xfer_wr), .tap(tap), .row_in(row_in),
    .row_wdata(row_wdata), .row_we(row_we), .ser_step(ser_step), .ser_din(ser_din),
    .ser_dout(ser_dout), .half_flag(half_flag), .xfer_err(xfer_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [RW-1:0] pat(input int seed);
    logic [RW-1:0] r;
    for (int n = 0; n < DEPTH; n++) r[n*DW +: DW] = DW'((n * (2*seed + 3) + seed) & 15);
    return r;
  endfunction

  function automatic logic [RW-1:0] model_bank();
    logic [RW-1:0] r;
    for (int n = 0; n < DEPTH; n++) r[n*DW +: DW] = m_mem[n];
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock with the given inputs; model computed from the requirements
  task automatic drive(input string req, input bit sp, input bit din_mode, input bit rd,
                       input bit wr, input bit st, input logic [AW-1:0] t,
                       input logic [DW-1:0] d, input logic [RW-1:0] row);
    logic          act, rd_hit, wr_hit, full, e_err;
    logic [1:0]    e_we;
    logic [DW-1:0] nm [DEPTH];
    logic [AW-1:0] np;
    logic [AW-2:0] no;
    split_mode = sp; ser_in_mode = din_mode; xfer_rd = rd; xfer_wr = wr;
    ser_step = st; tap = t; ser_din = d; row_in = row;
    act    = m_ptr[AW-1];
    rd_hit = sp && rd && (t[AW-1] == act);
    wr_hit = sp && wr && (t[AW-1] == act);
    full   = rd && !sp;
    e_err  = rd_hit || wr_hit;
    e_we   = !wr ? 2'b00 : (!sp ? 2'b11 : (wr_hit ? 2'b00 : (t[AW-1] ? 2'b10 : 2'b01)));
    for (int n = 0; n < DEPTH; n++) begin
      nm[n] = m_mem[n];
      if (full || (sp && rd && !rd_hit && ((n >= DEPTH/2) == t[AW-1])))
        nm[n] = row[n*DW +: DW];
    end
    if (st && din_mode && !full) nm[m_ptr] = d;
    no = (sp && rd && !rd_hit) ? t[AW-2:0] : m_ofs;
    np = m_ptr;
    if (full) np = t;
    else if (st) begin
      if (sp && (m_ptr[AW-2:0] == '1)) np = {~m_ptr[AW-1], no};
      else                             np = m_ptr + 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    for (int n = 0; n < DEPTH; n++) m_mem[n] = nm[n];
    m_ptr = np; m_ofs = no;
    xfer_rd = 0; xfer_wr = 0; ser_step = 0;
    chk(req, "ser_dout", RW'(ser_dout), RW'(m_mem[m_ptr]));
    chk(req, "half_flag", RW'(half_flag), RW'(m_ptr[AW-1]));
    chk(req, "xfer_err", RW'(xfer_err), RW'(e_err));
    chk(req, "row_we", RW'(row_we), RW'(e_we));
    if (e_we != 2'b00) chk(req, "row_wdata", row_wdata, model_bank());
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; split_mode = 0; ser_in_mode = 0; xfer_rd = 0; xfer_wr = 0;
    ser_step = 0; tap = '0; ser_din = '0; row_in = '0;
    for (int n = 0; n < DEPTH; n++) m_mem[n] = '0;
    m_ptr = '0; m_ofs = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ser_dout", RW'(ser_dout), '0);
    chk("R1", "half_flag", RW'(half_flag), '0);
    chk("R1", "row_we", RW'(row_we), '0);
    chk("R1", "xfer_err", RW'(xfer_err), '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "half_flag after release", RW'(half_flag), '0);
    chk("R1", "row_we after release", RW'(row_we), '0);

    // R5 handover with the reset offset of 0
    for (int k = 0; k < 16; k++) drive("R5", 1, 0, 0, 0, 1, '0, '0, '0);

    // R2 full load at every tap
    for (int t = 0; t < DEPTH; t++) drive("R2", 0, 0, 1, 0, 0, AW'(t), '0, pat(1));

    // R3 / R4 streaming through the wrap
    for (int k = 0; k < 20; k++) drive("R4", 0, 0, 0, 0, 1, '0, '0, '0);
    for (int k = 0; k < 3; k++)  drive("R3", 0, 0, 0, 0, 0, '0, '0, '0);

    // R9 single-mode transfer write, then idle
    drive("R9", 0, 0, 0, 1, 0, '0, '0, '0);
    drive("R9", 0, 0, 0, 0, 0, '0, '0, '0);

    // R8 serial input over the whole ring, then write back
    for (int k = 0; k < DEPTH; k++) drive("R8", 0, 1, 0, 0, 1, '0, DW'((k*3 + 5) & 15), '0);
    drive("R8", 0, 0, 0, 1, 0, '0, '0, '0);

    // R10 load beats a simultaneous serial write
    drive("R10", 0, 1, 1, 0, 1, AW'(9), 4'hF, pat(2));
    drive("R10", 0, 0, 0, 0, 0, '0, '0, '0);

    // split: pointer at 9 (upper active); R6 reload lower with offset 2
    drive("R6", 1, 0, 1, 0, 0, AW'(2), '0, pat(3));
    for (int k = 0; k < 8; k++) drive("R6", 1, 0, 0, 0, 1, '0, '0, '0);

    // R7 refused transfers to the active half (lower)
    drive("R7", 1, 0, 1, 0, 0, AW'(3), '0, pat(4));
    drive("R7", 1, 0, 0, 1, 0, AW'(5), '0, '0);
    drive("R7", 1, 0, 0, 0, 0, '0, '0, '0);

    // R9 split write-back of the inactive upper half
    drive("R9", 1, 0, 0, 1, 0, AW'(12), '0, '0);

    // R11 reload coinciding with the handover step
    while (m_ptr[AW-2:0] != '1) drive("R11", 1, 0, 0, 0, 1, '0, '0, '0);
    drive("R11", 1, 0, 1, 0, 1, {~m_ptr[AW-1], 3'd6}, '0, pat(5));

    // R5 / R6 sweep of every offset, with serial input in the active half
    for (int o = 0; o < DEPTH/2; o++) begin
      drive("R6", 1, 0, 1, 0, 0, {~m_ptr[AW-1], 3'(o)}, '0, pat(6 + o));
      for (int k = 0; k < 8; k++) drive("R5", 1, o[0], 0, 0, 1, '0, DW'(o + k), '0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule